// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a serial slave that gives a host access to a small byte-wide register map. It holds the setup values for an attached converter core. The host talks to it over an active-low select line, a serial clock and one shared bidirectional data pin. A separate parallel bus carries the current calibration settings and the channel-select state to the core at all times.

Each transaction starts with one instruction byte: a read/write flag and a 7-bit start address. Data bytes follow, and the address moves up by one after each byte, so a single address phase can reach a run of registers. In select-line mode, releasing the select line ends the burst. In select-free mode the select line is ignored. The burst then stops after the byte whose address matches a programmable end register, and the next bit is the first bit of a new instruction.

A port-setup register picks the bit order at run time and can restore every register to its default. The offset and gain registers are indexed. They can only be written once the channel-select register enables channel 0, and while it does not, any read of them returns a fixed error byte. All serial inputs pass through synchronisers on the system clock, so the serial clock must be several times slower than the system clock.

Top module: `spi_cfg_slave`

## Requirements
- R1: After rst, chan_sel_o is 0, the five calibration outputs equal their parameter defaults, address 0x00 reads 0x18, address 0x02 reads 0x00 and address 0x10 reads 0x00.
- R2: In the default bit order, the instruction byte is sent as the flag first (1 = read) and then address bits 6 down to 0. Data bytes are sent bit 7 first. The slave samples spi_sdio on rising spi_sclk and changes its output after falling spi_sclk. It drives read data from the falling edge that follows the eighth instruction bit.
- R3: One instruction followed by several data bytes reads or writes consecutive addresses, starting at the instruction's address and rising by one per byte.
- R4: With two_wire_mode low, spi_csn high aborts any burst or partial byte, releases spi_sdio, and blocks every register write, whatever spi_sclk and spi_sdio do.
- R5: With two_wire_mode high, spi_csn is ignored. A burst ends after the byte at the address held in register 0x02, and the following bit starts a new instruction.
- R6: Writing 0x00 with bit 6 set selects the reversed bit order. The instruction is then sent as the flag, then address bits 0 up to 6, and data goes bit 0 first. Address 0x00 then reads 0x5A; with bit 6 clear it reads 0x18.
- R7: Writing 0x00 with bit 5 set restores every register to its default within two system clocks, including the bit order. Bit 5 always reads back 0.
- R8: Address 0x08 reads the CHIP_ID parameter and 0x09 reads the CHIP_REV parameter. Writes to both are ignored.
- R9: Address 0x10 stores only its bit 0 (channel 0 selected) and reads back as {7'b0, bit0}. The same bit drives chan_sel_o.
- R10: While chan_sel_o is 0, a read of any indexed address 0x20 to 0x24 returns 0xAD.
- R11: Writes to 0x20 (coarse offset), 0x21 (fine offset), 0x22 (coarse gain, bits 3:0 kept), 0x23 (medium gain) and 0x24 (fine gain) take effect only while chan_sel_o is 1. They appear on the matching outputs.
- R12: Any address outside the map reads 0x00, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| two_wire_mode | input | 1 | 1: select-free framing ended by the end register; 0: framing by spi_csn |
| spi_csn | input | 1 | Active-low select, used only when two_wire_mode is 0 |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_sdio | inout | 1 | Shared serial data line |
| chan_sel_o | output | 1 | Channel 0 selected for indexed access |
| off_coarse_o | output | 8 | Coarse offset setting |
| off_fine_o | output | 8 | Fine offset setting |
| gain_coarse_o | output | 4 | Coarse gain setting |
| gain_med_o | output | 8 | Medium gain setting |
| gain_fine_o | output | 8 | Fine gain setting |

## Verification
Single-byte and multi-byte transfers in both directions check that the address advances correctly and that the read path drives the line at the right time. The same writes are repeated with no channel selected and with channel 0 selected, which shows the gate working on both the read data and the core outputs. A byte that is not its own bit-reverse, written in the reversed order, shows whether the slave truly swapped the order. A burst cut off mid-byte, and clock pulses sent while the select line is high, show whether stray activity can change a register. Select-free bursts with the end register set to a middle address check that the burst stops there and that the next instruction is picked up straight after.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    typedef enum logic {
        PH_INSTR = 1'b0,
        PH_DATA  = 1'b1
    } phase_e;

    localparam logic [ADDR_W-1:0] A_PORTCFG  = 7'h00;
    localparam logic [ADDR_W-1:0] A_BURSTEND = 7'h02;
    localparam logic [ADDR_W-1:0] A_CHIPID   = 7'h08;
    localparam logic [ADDR_W-1:0] A_CHIPREV  = 7'h09;
    localparam logic [ADDR_W-1:0] A_CHANIDX  = 7'h10;
    localparam logic [ADDR_W-1:0] A_OFFC     = 7'h20;
    localparam logic [ADDR_W-1:0] A_OFFF     = 7'h21;
    localparam logic [ADDR_W-1:0] A_GAINC    = 7'h22;
    localparam logic [ADDR_W-1:0] A_GAINM    = 7'h23;
    localparam logic [ADDR_W-1:0] A_GAINF    = 7'h24;

    localparam logic [BYTE_W-1:0] IDX_ERR_BYTE = 8'hAD;

    // bit positions inside the port-setup byte
    localparam int PC_ORDER_BIT = 6;
    localparam int PC_SOFT_BIT  = 5;

    typedef struct packed {
        logic [BYTE_W-1:0] off_c;
        logic [BYTE_W-1:0] off_f;
        logic [3:0]        gain_c;
        logic [BYTE_W-1:0] gain_m;
        logic [BYTE_W-1:0] gain_f;
    } cal_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic logic is_indexed(input logic [ADDR_W-1:0] a);
        return (a >= A_OFFC) && (a <= A_GAINF);
    endfunction

    // Read image of the port-setup register: upper nibble mirrored into the lower one.
    function automatic logic [BYTE_W-1:0] portcfg_image(input logic lsb);
        logic [3:0] hi;
        hi = {1'b0, lsb, 1'b0, 1'b1};
        return {hi, hi[0], hi[1], hi[2], hi[3]};
    endfunction

    // Shift one serial bit into the byte register for the chosen order.
    function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] sr,
                                                   input logic b,
                                                   input logic lsb);
        return lsb ? {b, sr[BYTE_W-1:1]} : {sr[BYTE_W-2:0], b};
    endfunction

endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
    parameter int W       = 3,
    parameter int STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[s] <= RST_VAL;
                end else if (s == 0) begin
                    stage_q[s] <= din;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/spi_cfg_frame.sv
module spi_cfg_frame
    import spi_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              two_wire,
    input  logic              csn_s,
    input  logic              sclk_s,
    input  logic              sdi_s,
    input  logic              lsb_first,
    input  logic [BYTE_W-1:0] burst_end,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output wr_req_t           wr,
    output logic              sdo_en,
    output logic              sdo_bit
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    phase_e            phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] shreg_q;
    logic [BYTE_W-1:0] tx_q;
    logic [ADDR_W-1:0] addr_q;
    logic              rw_q;
    logic              sclk_d;

    logic              active, rise, fall, byte_done, last_byte;
    logic [BYTE_W-1:0] nb;
    logic [ADDR_W-1:0] instr_addr, addr_inc;
    logic              instr_rw;

    always_comb begin
        active     = two_wire || !csn_s;
        rise       = sclk_s && !sclk_d;
        fall       = !sclk_s && sclk_d;
        nb         = shift_in(shreg_q, sdi_s, lsb_first);
        byte_done  = active && rise && (cnt_q == LAST_BIT);
        instr_addr = lsb_first ? nb[BYTE_W-1:1] : nb[ADDR_W-1:0];
        instr_rw   = lsb_first ? nb[0] : nb[BYTE_W-1];
        addr_inc   = addr_q + 7'd1;
        last_byte  = two_wire && ({1'b0, addr_q} == burst_end);
        rd_addr    = (phase_q == PH_INSTR) ? instr_addr : addr_inc;
        wr.en      = byte_done && (phase_q == PH_DATA) && !rw_q;
        wr.addr    = addr_q;
        wr.data    = nb;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_INSTR;
            cnt_q   <= '0;
            shreg_q <= '0;
            tx_q    <= '0;
            addr_q  <= '0;
            rw_q    <= 1'b0;
            sclk_d  <= 1'b0;
            sdo_en  <= 1'b0;
            sdo_bit <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            if (!active) begin
                phase_q <= PH_INSTR;
                cnt_q   <= '0;
                sdo_en  <= 1'b0;
            end else if (rise) begin
                shreg_q <= nb;
                cnt_q   <= cnt_q + 1'b1;
                if (cnt_q == LAST_BIT) begin
                    if (phase_q == PH_INSTR) begin
                        rw_q    <= instr_rw;
                        addr_q  <= instr_addr;
                        tx_q    <= rd_data;
                        phase_q <= PH_DATA;
                    end else if (last_byte) begin
                        phase_q <= PH_INSTR;
                        sdo_en  <= 1'b0;
                    end else begin
                        addr_q <= addr_inc;
                        tx_q   <= rd_data;
                    end
                end
            end else if (fall) begin
                sdo_en  <= (phase_q == PH_DATA) && rw_q;
                sdo_bit <= lsb_first ? tx_q[cnt_q] : tx_q[LAST_BIT - cnt_q];
            end
        end
    end
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
    import spi_cfg_pkg::*;
#(
    parameter logic [7:0] CHIP_ID   = 8'h5C,
    parameter logic [7:0] CHIP_REV  = 8'h03,
    parameter logic [7:0] OFFC_DEF  = 8'h7E,
    parameter logic [7:0] OFFF_DEF  = 8'h83,
    parameter logic [3:0] GAINC_DEF = 4'h0,
    parameter logic [7:0] GAINM_DEF = 8'h91,
    parameter logic [7:0] GAINF_DEF = 8'h6C
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              lsb_first,
    output logic [BYTE_W-1:0] burst_end,
    output logic              chan_sel,
    output cal_t              cal
);
    localparam cal_t CAL_DEF = '{off_c: OFFC_DEF, off_f: OFFF_DEF, gain_c: GAINC_DEF,
                                 gain_m: GAINM_DEF, gain_f: GAINF_DEF};

    logic soft_q;
    logic idx_ok;

    assign idx_ok = chan_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            soft_q <= 1'b0;
        end else begin
            soft_q <= wr.en && (wr.addr == A_PORTCFG) && wr.data[PC_SOFT_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_q) begin
            lsb_first <= 1'b0;
            burst_end <= '0;
            chan_sel  <= 1'b0;
            cal       <= CAL_DEF;
        end else if (wr.en) begin
            case (wr.addr)
                A_PORTCFG:  if (!wr.data[PC_SOFT_BIT]) lsb_first <= wr.data[PC_ORDER_BIT];
                A_BURSTEND: burst_end <= wr.data;
                A_CHANIDX:  chan_sel  <= wr.data[0];
                A_OFFC:     if (idx_ok) cal.off_c  <= wr.data;
                A_OFFF:     if (idx_ok) cal.off_f  <= wr.data;
                A_GAINC:    if (idx_ok) cal.gain_c <= wr.data[3:0];
                A_GAINM:    if (idx_ok) cal.gain_m <= wr.data;
                A_GAINF:    if (idx_ok) cal.gain_f <= wr.data;
                default:    ;
            endcase
        end
    end

    always_comb begin
        if (is_indexed(rd_addr) && !idx_ok) begin
            rd_data = IDX_ERR_BYTE;
        end else begin
            case (rd_addr)
                A_PORTCFG:  rd_data = portcfg_image(lsb_first);
                A_BURSTEND: rd_data = burst_end;
                A_CHIPID:   rd_data = CHIP_ID;
                A_CHIPREV:  rd_data = CHIP_REV;
                A_CHANIDX:  rd_data = {7'b0, chan_sel};
                A_OFFC:     rd_data = cal.off_c;
                A_OFFF:     rd_data = cal.off_f;
                A_GAINC:    rd_data = {4'b0, cal.gain_c};
                A_GAINM:    rd_data = cal.gain_m;
                A_GAINF:    rd_data = cal.gain_f;
                default:    rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
    import spi_cfg_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] CHIP_ID   = 8'h5C,
    parameter logic [7:0] CHIP_REV  = 8'h03,
    parameter logic [7:0] OFFC_DEF  = 8'h7E,
    parameter logic [7:0] OFFF_DEF  = 8'h83,
    parameter logic [3:0] GAINC_DEF = 4'h0,
    parameter logic [7:0] GAINM_DEF = 8'h91,
    parameter logic [7:0] GAINF_DEF = 8'h6C
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       two_wire_mode,
    input  logic       spi_csn,
    input  logic       spi_sclk,
    inout  wire        spi_sdio,
    output logic       chan_sel_o,
    output logic [7:0] off_coarse_o,
    output logic [7:0] off_fine_o,
    output logic [3:0] gain_coarse_o,
    output logic [7:0] gain_med_o,
    output logic [7:0] gain_fine_o
);
    logic [2:0]        pins_s;
    logic              csn_s, sclk_s, sdi_s;
    logic              lsb_first;
    logic [BYTE_W-1:0] burst_end;
    logic [BYTE_W-1:0] rd_data;
    logic [ADDR_W-1:0] rd_addr;
    wr_req_t           wr;
    logic              sdo_en, sdo_bit;
    cal_t              cal;

    spi_cfg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({spi_csn, spi_sclk, spi_sdio}),
        .dout (pins_s)
    );

    assign {csn_s, sclk_s, sdi_s} = pins_s;

    spi_cfg_frame u_frame (
        .clk       (clk),
        .rst       (rst),
        .two_wire  (two_wire_mode),
        .csn_s     (csn_s),
        .sclk_s    (sclk_s),
        .sdi_s     (sdi_s),
        .lsb_first (lsb_first),
        .burst_end (burst_end),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr        (wr),
        .sdo_en    (sdo_en),
        .sdo_bit   (sdo_bit)
    );

    spi_cfg_regs #(
        .CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV), .OFFC_DEF(OFFC_DEF), .OFFF_DEF(OFFF_DEF),
        .GAINC_DEF(GAINC_DEF), .GAINM_DEF(GAINM_DEF), .GAINF_DEF(GAINF_DEF)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .lsb_first (lsb_first),
        .burst_end (burst_end),
        .chan_sel  (chan_sel_o),
        .cal       (cal)
    );

    assign spi_sdio      = sdo_en ? sdo_bit : 1'bz;
    assign off_coarse_o  = cal.off_c;
    assign off_fine_o    = cal.off_f;
    assign gain_coarse_o = cal.gain_c;
    assign gain_med_o    = cal.gain_m;
    assign gain_fine_o   = cal.gain_f;
endmodule

// File: rtl/spi_cfg_slave_chk.sv
module spi_cfg_slave_chk
    import spi_cfg_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       two_wire_mode,
    input logic       csn_s,
    input logic       sdo_en,
    input wr_req_t    wr,
    input logic       lsb_first,
    input logic       chan_sel_o,
    input logic [7:0] off_coarse_o,
    input logic [7:0] off_fine_o,
    input logic [3:0] gain_coarse_o,
    input logic [7:0] gain_med_o,
    input logic [7:0] gain_fine_o
);
    AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!two_wire_mode && csn_s) |=> !sdo_en); // R4

    AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!two_wire_mode && csn_s) |-> !wr.en); // R4

    AST_IDX_GATE: assert property (@(posedge clk) disable iff (rst)
        (wr.en && is_indexed(wr.addr) && !chan_sel_o) |=>
        ($stable(off_coarse_o) && $stable(off_fine_o) && $stable(gain_coarse_o) &&
         $stable(gain_med_o) && $stable(gain_fine_o))); // R11

    AST_IDX_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.addr == A_OFFF && chan_sel_o) |=> (off_fine_o == $past(wr.data))); // R11

    AST_SOFT_DEFAULT: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.addr == A_PORTCFG && wr.data[PC_SOFT_BIT]) |-> ##2
        (!lsb_first && !chan_sel_o)); // R7
endmodule

bind spi_cfg_slave spi_cfg_slave_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .two_wire_mode (two_wire_mode),
    .csn_s         (csn_s),
    .sdo_en        (sdo_en),
    .wr            (wr),
    .lsb_first     (lsb_first),
    .chan_sel_o    (chan_sel_o),
    .off_coarse_o  (off_coarse_o),
    .off_fine_o    (off_fine_o),
    .gain_coarse_o (gain_coarse_o),
    .gain_med_o    (gain_med_o),
    .gain_fine_o   (gain_fine_o)
);

// File: tb/spi_cfg_slave_tb_top.sv
module spi_cfg_slave_tb_top;
    localparam int HALF = 8;
    localparam logic [7:0] E_ID = 8'h5C, E_REV = 8'h03;
    localparam logic [7:0] E_OFFC = 8'h7E, E_OFFF = 8'h83, E_GAINM = 8'h91, E_GAINF = 8'h6C;
    localparam logic [3:0] E_GAINC = 4'h0;

    logic clk = 1'b0, rst = 1'b1;
    logic two_wire = 1'b0, csn = 1'b1, sclk = 1'b0;
    logic tb_en = 1'b0, tb_bit = 1'b0;
    logic mode_lsb = 1'b0;
    wire  spi_sdio;
    logic chan_sel;
    logic [7:0] offc, offf, gainm, gainf;
    logic [3:0] gainc;
    int checks = 0, errors = 0;

    assign spi_sdio = tb_en ? tb_bit : 1'bz;

    always #5 clk = ~clk;

    spi_cfg_slave dut_i (
        .clk(clk), .rst(rst), .two_wire_mode(two_wire), .spi_csn(csn), .spi_sclk(sclk),
        .spi_sdio(spi_sdio), .chan_sel_o(chan_sel), .off_coarse_o(offc), .off_fine_o(offf),
        .gain_coarse_o(gainc), .gain_med_o(gainm), .gain_fine_o(gainf)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic bit_io(input logic drv, input logic b, output logic s);
        @(negedge clk);
        tb_en  = drv;
        tb_bit = b;
        repeat (HALF) @(negedge clk);
        s    = spi_sdio;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        logic s;
        for (int i = 0; i < 8; i++) bit_io(1'b1, mode_lsb ? b[i] : b[7-i], s);
    endtask

    task automatic recv_byte(output logic [7:0] b);
        logic s;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            bit_io(1'b0, 1'b0, s);
            if (mode_lsb) b[i] = s; else b[7-i] = s;
        end
    endtask

    task automatic begin_txn(input logic rw, input logic [6:0] a);
        if (!two_wire) begin
            @(negedge clk) csn = 1'b0;
            repeat (4) @(negedge clk);
        end
        send_byte(mode_lsb ? {a, rw} : {rw, a});
    endtask

    task automatic end_txn();
        repeat (4) @(negedge clk);
        tb_en = 1'b0;
        if (!two_wire) csn = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic wr1(input logic [6:0] a, input logic [7:0] d);
        begin_txn(1'b0, a); send_byte(d); end_txn();
    endtask

    task automatic rd1(input logic [6:0] a, output logic [7:0] d);
        begin_txn(1'b1, a); recv_byte(d); end_txn();
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 chan_sel", {7'b0, chan_sel}, 8'h00);
        chk("R1 off_coarse", offc, E_OFFC);
        chk("R1 off_fine", offf, E_OFFF);
        chk("R1 gain_coarse", {4'b0, gainc}, {4'b0, E_GAINC});
        chk("R1 gain_med", gainm, E_GAINM);
        chk("R1 gain_fine", gainf, E_GAINF);
        rd1(7'h00, d); chk("R1 portcfg", d, 8'h18);
        rd1(7'h02, d); chk("R1 burst end", d, 8'h00);
        rd1(7'h10, d); chk("R1 chan index", d, 8'h00);
    endtask

    task automatic t_ident();
        logic [7:0] d0, d1;
        begin_txn(1'b1, 7'h08); recv_byte(d0); recv_byte(d1); end_txn();
        chk("R2 R3 R8 id burst", d0, E_ID);
        chk("R3 R8 rev burst", d1, E_REV);
        wr1(7'h08, 8'h11); wr1(7'h09, 8'h22);
        rd1(7'h08, d0); chk("R8 id write ignored", d0, E_ID);
        rd1(7'h09, d0); chk("R8 rev write ignored", d0, E_REV);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        wr1(7'h05, 8'h77);
        rd1(7'h05, d); chk("R12 unmapped read", d, 8'h00);
        rd1(7'h7F, d); chk("R12 top address read", d, 8'h00);
    endtask

    task automatic t_idx_locked();
        logic [7:0] d0, d1;
        begin_txn(1'b1, 7'h20); recv_byte(d0); recv_byte(d1); end_txn();
        chk("R10 locked 0x20", d0, 8'hAD);
        chk("R10 locked 0x21", d1, 8'hAD);
        wr1(7'h21, 8'h55);
        chk("R11 locked write off_fine", offf, E_OFFF);
    endtask

    task automatic t_idx_open();
        logic [7:0] d;
        logic [7:0] vals [5];
        vals = '{8'hA1, 8'hB2, 8'hF5, 8'hC4, 8'hD6};
        wr1(7'h10, 8'hFF);
        rd1(7'h10, d); chk("R9 index keeps bit0", d, 8'h01);
        chk("R9 chan_sel", {7'b0, chan_sel}, 8'h01);
        rd1(7'h21, d); chk("R11 unlocked write blocked earlier", d, E_OFFF);
        begin_txn(1'b0, 7'h20);
        for (int i = 0; i < 5; i++) send_byte(vals[i]);
        end_txn();
        chk("R3 R11 off_coarse", offc, 8'hA1);
        chk("R3 R11 off_fine", offf, 8'hB2);
        chk("R11 gain_coarse 4 bits", {4'b0, gainc}, 8'h05);
        chk("R3 R11 gain_med", gainm, 8'hC4);
        chk("R3 R11 gain_fine", gainf, 8'hD6);
        begin_txn(1'b1, 7'h20);
        for (int i = 0; i < 5; i++) begin
            recv_byte(d);
            chk("R3 burst readback", d, (i == 2) ? 8'h05 : vals[i]);
        end
        end_txn();
    endtask

    task automatic t_abort();
        logic s;
        logic [7:0] d;
        begin_txn(1'b0, 7'h23);
        for (int i = 0; i < 4; i++) bit_io(1'b1, 1'b1, s);
        end_txn();
        chk("R4 partial byte no write", gainm, 8'hC4);
        for (int i = 0; i < 16; i++) bit_io(1'b1, (i == 2), s);
        tb_en = 1'b0;
        repeat (8) @(negedge clk);
        chk("R4 clocks while deselected", offc, 8'hA1);
        rd1(7'h23, d); chk("R4 frame restarts after abort", d, 8'hC4);
    endtask

    task automatic t_lsb();
        logic [7:0] d0, d1;
        wr1(7'h00, 8'h5A);
        mode_lsb = 1'b1;
        rd1(7'h00, d0); chk("R6 portcfg reversed order", d0, 8'h5A);
        begin_txn(1'b1, 7'h08); recv_byte(d0); recv_byte(d1); end_txn();
        chk("R6 id reversed order", d0, E_ID);
        chk("R6 rev reversed order", d1, E_REV);
        wr1(7'h24, 8'h3B);
        chk("R6 gain_fine reversed write", gainf, 8'h3B);
        wr1(7'h00, 8'h18);
        mode_lsb = 1'b0;
        rd1(7'h00, d0); chk("R2 R6 back to msb first", d0, 8'h18);
    endtask

    task automatic t_two_wire();
        logic [7:0] d0, d1;
        wr1(7'h02, 8'h23);
        @(negedge clk) two_wire = 1'b1;
        repeat (8) @(negedge clk);
        begin_txn(1'b0, 7'h22); send_byte(8'h07); send_byte(8'h99); end_txn();
        chk("R5 gain_coarse", {4'b0, gainc}, 8'h07);
        chk("R5 gain_med", gainm, 8'h99);
        begin_txn(1'b1, 7'h22); recv_byte(d0); recv_byte(d1);
        begin_txn(1'b0, 7'h23); send_byte(8'h44); end_txn();
        chk("R5 read 0x22", d0, 8'h07);
        chk("R5 read 0x23", d1, 8'h99);
        chk("R5 next instruction after end", gainm, 8'h44);
        chk("R5 0x24 untouched", gainf, 8'h3B);
        @(negedge clk) two_wire = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_soft();
        logic [7:0] d;
        wr1(7'h00, 8'h3C);
        chk("R7 chan_sel", {7'b0, chan_sel}, 8'h00);
        chk("R7 off_coarse", offc, E_OFFC);
        chk("R7 gain_med", gainm, E_GAINM);
        chk("R7 gain_fine", gainf, E_GAINF);
        rd1(7'h00, d); chk("R7 portcfg self clear", d, 8'h18);
        rd1(7'h02, d); chk("R7 burst end", d, 8'h00);
        rd1(7'h20, d); chk("R7 R10 indexed locked", d, 8'hAD);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset();
        t_ident();
        t_unmapped();
        t_idx_locked();
        t_idx_open();
        t_abort();
        t_lsb();
        t_two_wire();
        t_soft();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule